// File: doc/BRIEF.md
# Shared-Pin SPI Port

This block is a byte-wide serial peripheral interface engine that can act either as the clock-producing master or as a selected slave. Its four serial lines (clock, master-to-slave data, slave-to-master data, active-low select) share pins with an ordinary general-purpose port. The engine never drives a pin by itself. For every pin it produces a bypass bit, and the pin value is the port data bit ANDed with that bypass bit. Software must keep a port bit at 1 for the serial value on that pin to come through. When the engine is off, or a pin has an input role, the bypass bit is 1, so the port behaves as plain GPIO.

Software programs a control register that holds the role, the clock polarity, the clock phase, a clock-rate divider for master mode and an interrupt enable. It writes a byte to start a master transfer, or to preload the reply for a slave transfer, and reads back the received byte. Bits move most significant first. A completion flag is set once per finished byte and drives the interrupt line through the enable bit. In slave mode, releasing select in the middle of a byte discards the partial byte without raising the flag. In master mode the block produces no select; software drives one on any spare port bit.

Top module: `spi_gpio_port`

## Requirements
- R1: With the role field (control bits [1:0]) at 00 or 11, every bit of `pin_bypass` is 1 and `pin_out` equals `port_data`, whatever the activity on `pin_in`.
- R2: In master role (01), pins 2 (slave-to-master data) and 3 (select) keep bypass 1. Pin 0 carries the serial clock and pin 1 carries master-to-slave data, each ANDed with its `port_data` bit.
- R3: In slave role (10), pins 0, 1 and 3 keep bypass 1. Pin 2 carries the slave's output bit ANDed with `port_data[2]`, and it is 1 while select (`pin_in[3]`) is high.
- R4: A master transfer produces exactly 16 clock edges. The clock rests at the polarity bit (control bit 2) before the transfer and after it.
- R5: The master clock half period is 2 << div system clocks, where div is control bits [5:4].
- R6: For each combination of polarity and phase (control bit 3), data is sent and received most significant bit first. With phase 0 the first bit is set up before the first edge and captured on leading edges. With phase 1 bits change on leading edges and are captured on trailing edges.
- R7: The completion flag (status bit 0, address 2) is set after a whole byte. It is cleared by a read of the data register (address 1) or by a write to it. `irq` equals the flag ANDed with the enable bit (control bit 6).
- R8: In slave role, clock edges while select is high are ignored: no flag, and the received byte and the bit position stay unchanged.
- R9: In slave role with phase 0, the most significant bit of the preloaded byte appears on pin 2 once select falls, before any clock edge.
- R10: If select rises in the middle of a slave byte, the partial byte is dropped, no flag is raised, and the next full byte is received correctly.
- R11: A data write during a master transfer is ignored: the byte in flight is sent unchanged, and status bit 1 (busy) reads 1.
- R12: The control register (address 0, bits [6:0]) reads back the written value, and after reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| port_data | input | 4 | Port data register bits for pins 0..3 |
| pin_in | input | 4 | Pin levels: 0 clock, 1 master-to-slave, 2 slave-to-master, 3 select |
| pin_out | output | 4 | Port data ANDed with bypass, per pin |
| pin_bypass | output | 4 | Per-pin bypass bits |
| irq | output | 1 | Byte-complete interrupt request |

## Verification
The bench builds the block with the default 8-bit byte. All four divider settings are therefore reachable, and the bench measures half periods from 2 up to 16 system clocks. Master transfers run under all four polarity and phase combinations against a bench-side slave model. Slave transfers use a bench-side master that toggles the pins 8 clocks per half period, which is slow enough for the input synchronizers. That slow pace makes the select-fall setup, the aborted partial byte and the clock edges ignored while unselected directly observable.

// File: rtl/spi_gpio_pkg.sv
`timescale 1ns/1ps
package spi_gpio_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'b00,
    ROLE_MASTER = 2'b01,
    ROLE_SLAVE  = 2'b10,
    ROLE_PARK   = 2'b11
  } spi_role_e;

  localparam int CLK_DIV_W = 2;
  localparam int NUM_PINS  = 4;
  localparam int PIN_SCK   = 0;
  localparam int PIN_MOSI  = 1;
  localparam int PIN_MISO  = 2;
  localparam int PIN_SSN   = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic                 irq_en;
    logic [CLK_DIV_W-1:0] div;
    logic                 cpha;
    logic                 cpol;
    spi_role_e            role;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_gpio_regs.sv
`timescale 1ns/1ps
module spi_gpio_regs
  import spi_gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              tx_wr,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy,
  output logic              irq
);

  ctrl_t             ctrl_q, ctrl_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              ctrl_wr, data_rd;

  assign ctrl_wr = wr && (addr == ADDR_CTRL);
  assign tx_wr   = wr && (addr == ADDR_DATA);
  assign data_rd = rd && (addr == ADDR_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    rx_d = byte_done ? rx_byte : rx_q;
    done_d = done_q;
    if (tx_wr || data_rd) done_d = 1'b0;
    if (byte_done)        done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      done_q <= done_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_DATA: rdata = rx_q;
      ADDR_STAT: rdata[1:0] = {busy, done_q};
      default:   rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = done_q & ctrl_q.irq_en;

  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_q);
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !byte_done) |=> !done_q);
  p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/spi_gpio_sckgen.sv
`timescale 1ns/1ps
module spi_gpio_sckgen
  import spi_gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 start,
  input  logic                 cpol,
  input  logic [CLK_DIV_W-1:0] div,
  output logic                 sck,
  output logic                 lead,
  output logic                 trail,
  output logic                 busy
);

  localparam int HALF_W = (1 << CLK_DIV_W) + 1;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EW     = $clog2(EDGES);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [HALF_W-1:0] half_m1;
  logic              tick;

  assign half_m1 = (HALF_W'(2) << div) - HALF_W'(1);
  assign tick    = busy_q && (cnt_q == half_m1);

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    edge_d = edge_q;
    if (!en) begin
      busy_d = 1'b0;
      sck_d  = cpol;
      cnt_d  = '0;
      edge_d = '0;
    end else if (!busy_q) begin
      sck_d  = cpol;
      cnt_d  = '0;
      edge_d = '0;
      if (start) busy_d = 1'b1;
    end else if (tick) begin
      cnt_d  = '0;
      sck_d  = ~sck_q;
      edge_d = edge_q + EW'(1);
      if (edge_q == EW'(EDGES - 1)) busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
    end
  end

  assign sck   = sck_q;
  assign busy  = busy_q;
  assign lead  = tick && !edge_q[0];
  assign trail = tick &&  edge_q[0];

  p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q <= EW'(EDGES - 1)));
  p_half_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |-> $stable(sck_q));
  p_stay_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en && !tick) |=> busy_q);

endmodule

// File: rtl/spi_gpio_shifter.sv
`timescale 1ns/1ps
module spi_gpio_shifter
  import spi_gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_master,
  input  logic                is_slave,
  input  logic                cpha,
  input  logic                cpol,
  input  logic                m_lead,
  input  logic                m_trail,
  input  logic                load,
  input  logic [DATA_W-1:0]   load_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                out_bit,
  output logic [DATA_W-1:0]   rx_byte,
  output logic                byte_done,
  output logic                active,
  output logic                selected
);

  localparam int CW = $clog2(DATA_W);
  localparam int NS = 3;
  localparam logic [NS-1:0] SYNC_RST = 3'b100;

  logic [NS-1:0] raw, s1_q, s2_q;
  assign raw = {pin_in[PIN_SSN], pin_in[PIN_MOSI], pin_in[PIN_SCK]};

  for (genvar i = 0; i < NS; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= SYNC_RST[i];
        s2_q[i] <= SYNC_RST[i];
      end else begin
        s1_q[i] <= raw[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  logic s_sck, s_mosi, s_ssn, sck_d_q, ssn_d_q;
  assign s_sck  = s2_q[0];
  assign s_mosi = s2_q[1];
  assign s_ssn  = s2_q[2];

  logic sel, s_edge, s_lead, s_trail, ssn_fall, ssn_rise;
  logic lead, trail, sample, launch, din, enabled, sample_ok;

  assign sel      = is_slave && !s_ssn;
  assign s_edge   = sel && (s_sck != sck_d_q);
  assign s_lead   = s_edge && (s_sck != cpol);
  assign s_trail  = s_edge && (s_sck == cpol);
  assign ssn_fall = is_slave && !s_ssn && ssn_d_q;
  assign ssn_rise = is_slave && s_ssn && !ssn_d_q;
  assign enabled  = is_master || is_slave;

  assign lead   = is_master ? m_lead  : s_lead;
  assign trail  = is_master ? m_trail : s_trail;
  assign sample = cpha ? trail : lead;
  assign launch = cpha ? lead  : trail;
  assign din    = is_master ? pin_in[PIN_MISO] : s_mosi;
  assign sample_ok = enabled && sample && !ssn_fall && !ssn_rise;

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              out_q, out_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    tx_d  = tx_q;
    out_d = out_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    if (!enabled) begin
      cnt_d = '0;
    end else if (ssn_fall || ssn_rise) begin
      cnt_d = '0;
      if (ssn_fall && !cpha) begin
        out_d = tx_q[DATA_W-1];
        tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      end
    end else begin
      if (load) begin
        if (is_master && !cpha) begin
          out_d = load_data[DATA_W-1];
          tx_d  = {load_data[DATA_W-2:0], 1'b0};
        end else begin
          tx_d = load_data;
        end
      end else if (launch) begin
        out_d = tx_q[DATA_W-1];
        tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      end
      if (sample_ok) begin
        rx_d  = {rx_q[DATA_W-2:0], din};
        cnt_d = (cnt_q == CW'(DATA_W - 1)) ? '0 : cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      out_q   <= 1'b0;
      rx_q    <= '0;
      cnt_q   <= '0;
      sck_d_q <= 1'b0;
      ssn_d_q <= 1'b1;
    end else begin
      tx_q    <= tx_d;
      out_q   <= out_d;
      rx_q    <= rx_d;
      cnt_q   <= cnt_d;
      sck_d_q <= s_sck;
      ssn_d_q <= s_ssn;
    end
  end

  assign out_bit   = out_q;
  assign rx_byte   = {rx_q[DATA_W-2:0], din};
  assign byte_done = sample_ok && (cnt_q == CW'(DATA_W - 1));
  assign active    = (cnt_q != '0);
  assign selected  = sel;

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DATA_W - 1));
  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ssn_rise |=> (cnt_q == '0));
  p_unselected_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && s_ssn && ssn_d_q) |=> ($stable(rx_q) && $stable(cnt_q)));
  p_fall_presents_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ssn_fall && !cpha) |=> (out_q == $past(tx_q[DATA_W-1])));

endmodule

// File: rtl/spi_gpio_pinmux.sv
`timescale 1ns/1ps
module spi_gpio_pinmux
  import spi_gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_master,
  input  logic                is_slave,
  input  logic                sck_o,
  input  logic                mosi_o,
  input  logic                miso_o,
  input  logic [NUM_PINS-1:0] port_data,
  output logic [NUM_PINS-1:0] bypass,
  output logic [NUM_PINS-1:0] pin_out
);

  logic [NUM_PINS-1:0] role_en, role_val;

  always_comb begin
    role_en  = '0;
    role_val = '1;
    if (is_master) begin
      role_en[PIN_SCK]   = 1'b1;
      role_val[PIN_SCK]  = sck_o;
      role_en[PIN_MOSI]  = 1'b1;
      role_val[PIN_MOSI] = mosi_o;
    end
    if (is_slave) begin
      role_en[PIN_MISO]  = 1'b1;
      role_val[PIN_MISO] = miso_o;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign bypass[i]  = role_en[i] ? role_val[i] : 1'b1;
    assign pin_out[i] = port_data[i] & bypass[i];
  end

  p_off_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !is_slave) |-> (pin_out == port_data));
  p_master_inputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (pin_out[PIN_MISO] == port_data[PIN_MISO] &&
                   pin_out[PIN_SSN]  == port_data[PIN_SSN]));
  p_slave_inputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (bypass[PIN_SCK] && bypass[PIN_MOSI] && bypass[PIN_SSN]));

endmodule

// File: rtl/spi_gpio_port.sv
`timescale 1ns/1ps
module spi_gpio_port
  import spi_gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] port_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_bypass,
  output logic                irq
);

  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  ctrl_t             ctrl;
  logic              tx_wr, byte_done, busy;
  logic [DATA_W-1:0] rx_byte;
  logic              is_master, is_slave;
  logic              m_sck, m_lead, m_trail, m_busy;
  logic              out_bit, s_active, s_sel, m_start, s_load, miso_o;

  assign is_master = (ctrl.role == ROLE_MASTER);
  assign is_slave  = (ctrl.role == ROLE_SLAVE);
  assign m_start   = tx_wr && is_master && !m_busy;
  assign s_load    = tx_wr && is_slave && !s_active;
  assign busy      = m_busy || s_active;
  assign miso_o    = s_sel ? out_bit : 1'b1;

  spi_gpio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .ctrl      (ctrl),
    .tx_wr     (tx_wr),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .busy      (busy),
    .irq       (irq)
  );

  spi_gpio_sckgen #(.DATA_W(DATA_W)) u_sckgen (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (is_master),
    .start (m_start),
    .cpol  (ctrl.cpol),
    .div   (ctrl.div),
    .sck   (m_sck),
    .lead  (m_lead),
    .trail (m_trail),
    .busy  (m_busy)
  );

  spi_gpio_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .is_master (is_master),
    .is_slave  (is_slave),
    .cpha      (ctrl.cpha),
    .cpol      (ctrl.cpol),
    .m_lead    (m_lead),
    .m_trail   (m_trail),
    .load      (m_start || s_load),
    .load_data (reg_wdata),
    .pin_in    (pin_in),
    .out_bit   (out_bit),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .active    (s_active),
    .selected  (s_sel)
  );

  spi_gpio_pinmux u_pinmux (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .is_master (is_master),
    .is_slave  (is_slave),
    .sck_o     (m_sck),
    .mosi_o    (out_bit),
    .miso_o    (miso_o),
    .port_data (port_data),
    .bypass    (pin_bypass),
    .pin_out   (pin_out)
  );

endmodule

// File: tb/tb_spi_gpio_port.sv
`timescale 1ns/1ps
module tb_spi_gpio_port;

  localparam int DW = 8;
  localparam int HP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [3:0]    port_data, pin_in, pin_out, pin_bypass;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_gpio_port #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_data(port_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_bypass(pin_bypass), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [DW-1:0] ctrl_word(input bit en, input logic [1:0] div,
                                               input bit cpha, input bit cpol,
                                               input logic [1:0] role);
    return {1'b0, en, div, cpha, cpol, role};
  endfunction

  task automatic peek_status(output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = 2'd2;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 reset bypass", pin_bypass, 4'hF);
    chk("R1 reset passthru", pin_out, port_data);
    chk("R7 reset irq", irq, 0);
    reg_read(2'd0, d); chk("R12 reset ctrl", d, 0);
    reg_read(2'd1, d); chk("R12 reset data", d, 0);
    reg_read(2'd2, d); chk("R12 reset status", d, 0);
  endtask

  task automatic t_off_modes;
    logic [DW-1:0] d;
    reg_write(2'd0, ctrl_word(1, 2'd1, 1, 1, 2'b11));
    reg_read(2'd0, d); chk("R12 ctrl readback", d, ctrl_word(1, 2'd1, 1, 1, 2'b11));
    for (int p = 0; p < 16; p += 5) begin
      port_data = 4'(p); pin_in = ~4'(p);
      repeat (3) @(negedge clk);
      chk("R1 parked passthru", pin_out, p);
      chk("R1 parked bypass", pin_bypass, 4'hF);
    end
    reg_write(2'd0, ctrl_word(0, 2'd0, 0, 0, 2'b00));
    port_data = 4'b1001; pin_in = 4'b0110;
    repeat (3) @(negedge clk);
    chk("R1 off passthru", pin_out, 4'b1001);
  endtask

  task automatic master_xfer(input bit cpol, input bit cpha, input logic [1:0] div,
                             input logic [DW-1:0] tx, input logic [DW-1:0] resp,
                             input bit ien, input bit inject);
    logic [DW-1:0] got, d;
    int toggles, since, mi, guard, half;
    bit prev, rate_ok, lead;
    half = 2 << div;
    port_data = 4'hF; pin_in = 4'hF;
    reg_write(2'd0, ctrl_word(ien, div, cpha, cpol, 2'b01));
    repeat (3) @(negedge clk);
    chk("R4 idle level before", pin_out[0], cpol);
    chk("R2 master miso/ss bypass", pin_bypass[3:2], 2'b11);
    pin_in[2] = cpha ? 1'b0 : resp[7];
    got = '0; toggles = 0; since = 0; mi = 0; guard = 0; rate_ok = 1; prev = pin_out[0];
    reg_write(2'd1, tx);
    while (toggles < 16 && guard < 4000) begin
      if (reg_wr) reg_wr = 1'b0;
      if (!(toggles == 6 && inject)) reg_addr = 2'd1;
      since++; guard++;
      if (pin_out[0] != prev) begin
        prev = pin_out[0];
        toggles++;
        if (toggles > 1 && since != half) rate_ok = 0;
        since = 0;
        lead = (toggles % 2) == 1;
        if (!cpha) begin
          if (lead) got = {got[DW-2:0], pin_out[1]};
          else begin mi++; if (mi < 8) pin_in[2] = resp[7-mi]; end
        end else begin
          if (lead) begin pin_in[2] = resp[7-mi]; mi++; end
          else got = {got[DW-2:0], pin_out[1]};
        end
        if (inject && toggles == 4) begin
          reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = ~tx;
        end
        if (inject && toggles == 6) begin
          reg_addr = 2'd2;
          #1 chk("R11 busy during transfer", reg_rdata[1], 1);
        end
      end
      @(negedge clk);
    end
    chk("R4 sixteen edges", toggles, 16);
    repeat (4) @(negedge clk);
    chk(inject ? "R11 byte unchanged" : "R6 mosi msb first", got, tx);
    chk("R5 half period", rate_ok, 1);
    chk("R4 idle level after", pin_out[0], cpol);
    peek_status(d);
    chk("R7 done flag", d[1:0], 2'b01);
    chk("R7 irq gated", irq, ien);
    reg_read(2'd1, d);
    chk("R6 master rx", d, resp);
    peek_status(d);
    chk("R7 read clears", d[0], 0);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_write_clears;
    logic [DW-1:0] d;
    master_xfer(0, 0, 2'd0, 8'h0F, 8'hF0, 1, 0);
    master_xfer(0, 0, 2'd0, 8'h11, 8'h22, 1, 0);
    reg_write(2'd0, ctrl_word(1, 2'd0, 0, 0, 2'b00));
    reg_write(2'd0, ctrl_word(1, 2'd0, 0, 0, 2'b01));
    port_data = 4'hF;
    reg_write(2'd1, 8'h33);
    repeat (80) @(negedge clk);
    peek_status(d); chk("R7 done before write", d[0], 1);
    reg_write(2'd0, ctrl_word(1, 2'd0, 0, 0, 2'b00));
    reg_write(2'd1, 8'h00);
    peek_status(d); chk("R7 write clears", d[0], 0);
    chk("R7 irq low after write", irq, 0);
  endtask

  task automatic slave_xfer(input bit cpol, input bit cpha, input logic [DW-1:0] mtx,
                            input logic [DW-1:0] stx, input int nbits);
    logic [DW-1:0] got, d;
    port_data = 4'hF;
    pin_in = {1'b1, 1'b1, 1'b0, cpol};
    reg_write(2'd0, ctrl_word(1, 2'd0, cpha, cpol, 2'b10));
    repeat (6) @(negedge clk);
    reg_write(2'd1, stx);
    pin_in[1] = mtx[7];
    pin_in[3] = 1'b0;
    repeat (HP) @(negedge clk);
    if (!cpha) chk("R9 msb after select", pin_out[2], stx[7]);
    got = '0;
    for (int b = 0; b < nbits; b++) begin
      if (!cpha) begin
        got = {got[DW-2:0], pin_out[2]};
        pin_in[0] = ~cpol;
        repeat (HP) @(negedge clk);
        pin_in[0] = cpol;
        if (b < 7) pin_in[1] = mtx[6-b];
        repeat (HP) @(negedge clk);
      end else begin
        pin_in[0] = ~cpol;
        pin_in[1] = mtx[7-b];
        repeat (HP) @(negedge clk);
        got = {got[DW-2:0], pin_out[2]};
        pin_in[0] = cpol;
        repeat (HP) @(negedge clk);
      end
    end
    pin_in[3] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 miso idle high", pin_out[2], 1);
    peek_status(d);
    if (nbits == 8) begin
      chk("R6 slave done", d[0], 1);
      chk("R6 slave miso", got, stx);
      reg_read(2'd1, d);
      chk("R6 slave rx", d, mtx);
    end else begin
      chk("R10 no done on abort", d[0], 0);
      chk("R10 no irq on abort", irq, 0);
    end
  endtask

  task automatic t_slave_gating;
    port_data = 4'hF;
    pin_in = 4'b1000;
    reg_write(2'd0, ctrl_word(0, 2'd0, 0, 0, 2'b10));
    reg_write(2'd1, 8'h80);
    pin_in[3] = 1'b0;
    repeat (HP) @(negedge clk);
    chk("R3 slave bypass inputs", {pin_bypass[3], pin_bypass[1:0]}, 3'b111);
    chk("R3 miso drives", pin_out[2], 1);
    port_data[2] = 1'b0;
    #1 chk("R3 miso masked", pin_out[2], 0);
    pin_in[3] = 1'b1;
    port_data = 4'hF;
    repeat (HP) @(negedge clk);
  endtask

  task automatic t_unselected;
    logic [DW-1:0] d;
    slave_xfer(0, 0, 8'h6D, 8'h92, 8);
    pin_in = 4'b1000;
    for (int k = 0; k < 16; k++) begin
      pin_in[0] = ~pin_in[0]; pin_in[1] = k[0];
      repeat (HP) @(negedge clk);
    end
    peek_status(d);
    chk("R8 no done unselected", d[1:0], 0);
    reg_read(2'd1, d);
    chk("R8 rx unchanged", d, 8'h6D);
    slave_xfer(0, 0, 8'hB4, 8'h4B, 8);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0;
    reg_wdata = '0; port_data = 4'b0110; pin_in = 4'b1000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_off_modes();
    master_xfer(0, 0, 2'd0, 8'hA5, 8'h3C, 1, 0);
    master_xfer(0, 1, 2'd1, 8'h81, 8'h7E, 0, 0);
    master_xfer(1, 0, 2'd2, 8'hC6, 8'h19, 1, 0);
    master_xfer(1, 1, 2'd3, 8'h5A, 8'hE7, 1, 0);
    master_xfer(0, 0, 2'd1, 8'h96, 8'h00, 1, 1);
    t_write_clears();
    t_slave_gating();
    slave_xfer(0, 0, 8'hA3, 8'h5C, 8);
    slave_xfer(1, 1, 8'h0F, 8'hF1, 8);
    slave_xfer(0, 1, 8'h99, 8'h66, 8);
    slave_xfer(1, 0, 8'h3E, 8'hC1, 8);
    t_unselected();
    slave_xfer(0, 1, 8'hAA, 8'h55, 3);
    slave_xfer(0, 1, 8'h5B, 8'hC4, 8);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule